// File: doc/BRIEF.md
# Data-Path DIP-4 Sync Monitor

This block sits behind the deserializer of a 16-bit packet data path, where each beat carries a word and a flag that marks it as a control word. It keeps a running diagonal parity over the payload and control words since the last checked control word. When the next control word arrives, it folds that parity to four bits and compares it with the four-bit check field the control word carries. A mismatch marks the control word, and the data that led up to it, as errored.

Two hysteresis counters turn the stream of check results into a sync decision. A run of errors longer than a bad threshold drops the monitor out of sync. After that, a run of error-free control words as long as a good threshold brings it back. Any error in the meantime restarts the good run.

A training-pattern detector recognises the training control word and the run of training data words that follows it. It keeps both out of the parity. The overall link sync output combines the external alignment lock with the parity state. When that sync is lost, the block asks the far end for training.

Top module: `dip4_sync_mon`

## Requirements
- R1: After reset, `dip_oos` is 1, `link_sync` is 0, `train_req` is 1, and `err_pulse` and `train_hit` are 0.
- R2: The check value is built by starting from zero and, for each counted word, rotating the 16-bit accumulator left by one bit and XORing in the word. The control word is counted with its bits [3:0] replaced by 4'b1111. The result's four nibbles are then XORed together. If this differs from bits [3:0] of the control word, `err_pulse` is 1 for exactly one cycle, in the cycle after the control word is accepted. If it matches, `err_pulse` stays 0.
- R3: The accumulator restarts from zero after every checked control word. Beats with `vld_in` low are ignored.
- R4: A control word equal to 16'h0FFF starts a training run. Data words equal to 16'hF000 that follow it within the run are training words. None of these words enter the parity. `train_hit` pulses for one cycle, in the cycle after the TRAIN_RUN-th consecutive training data word.
- R5: While in sync, `dip_oos` rises only when the count of consecutive errored control words exceeds BAD_THR. It rises two cycles after the control word that crosses the threshold.
- R6: An error-free control word clears the bad count, and an errored control word clears the good count.
- R7: While out of sync, `dip_oos` falls after GOOD_THR consecutive error-free control words, two cycles after the last of them.
- R8: `link_sync` is 1 exactly when `lock_in` is 1 and `dip_oos` is 0. `train_req` is the inverse of `link_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | 16 | Data or control word |
| ctl_in | input | 1 | Marks `word_in` as a control word |
| vld_in | input | 1 | Beat qualifier |
| lock_in | input | 1 | Alignment lock from the lane aligner |
| err_pulse | output | 1 | One-cycle pulse per parity mismatch |
| dip_oos | output | 1 | Parity out-of-sync state |
| train_hit | output | 1 | One-cycle pulse when a training pattern is detected |
| link_sync | output | 1 | Combined sync: lock and parity in sync |
| train_req | output | 1 | Request for a new training sequence |

## Verification
The bench builds the monitor with BAD_THR=2, GOOD_THR=3 and TRAIN_RUN=4. With these values, a short vector table can drive the monitor through a full round trip: into sync, through a sub-threshold error run broken by a good word, out of sync on the third error, and back in after an interrupted recovery.

The small TRAIN_RUN lets one directed test reach the training pulse. That same test then shows that the training words left the parity untouched. Directed cases add an empty segment, gaps with invalid beats, and lock loss.

// File: rtl/dip4_mon_pkg.sv
package dip4_mon_pkg;
  localparam logic [15:0] TRAIN_CTL_W = 16'h0FFF;
  localparam logic [15:0] TRAIN_DAT_W = 16'hF000;

  typedef enum logic [1:0] {
    WK_DATA  = 2'd0,
    WK_CTL   = 2'd1,
    WK_TRAIN = 2'd2,
    WK_NONE  = 2'd3
  } wkind_t;

  function automatic logic [15:0] dip_step(input logic [15:0] acc,
                                           input logic [15:0] w);
    return {acc[14:0], acc[15]} ^ w;
  endfunction

  function automatic logic [3:0] dip_fold(input logic [15:0] a);
    return a[15:12] ^ a[11:8] ^ a[7:4] ^ a[3:0];
  endfunction
endpackage

// File: rtl/dip4_accum.sv
module dip4_accum
  import dip4_mon_pkg::*;
#(
  parameter int TRAIN_RUN = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] word_in,
  input  logic        ctl_in,
  input  logic        vld_in,
  output logic        chk_vld,
  output logic        chk_bad,
  output logic        train_hit
);
  localparam int RW = $clog2(TRAIN_RUN + 1);

  logic [15:0]   acc_q;
  logic          in_train_q;
  logic [RW-1:0] run_q;
  logic          chk_vld_q, chk_bad_q, hit_q;

  logic          is_tctl, is_tdat;
  wkind_t        kind;
  logic [3:0]    calc_dip;

  assign is_tctl  = ctl_in && (word_in == TRAIN_CTL_W);
  assign is_tdat  = !ctl_in && (word_in == TRAIN_DAT_W);
  assign calc_dip = dip_fold(dip_step(acc_q, {word_in[15:4], 4'hF}));

  always_comb begin
    if (!vld_in)                          kind = WK_NONE;
    else if (is_tctl || (in_train_q && is_tdat)) kind = WK_TRAIN;
    else if (ctl_in)                      kind = WK_CTL;
    else                                  kind = WK_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      in_train_q <= 1'b0;
      run_q      <= '0;
      chk_vld_q  <= 1'b0;
      chk_bad_q  <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      chk_vld_q <= 1'b0;
      chk_bad_q <= 1'b0;
      hit_q     <= 1'b0;
      unique case (kind)
        WK_TRAIN: begin
          if (is_tctl) begin
            in_train_q <= 1'b1;
            run_q      <= '0;
          end else if (run_q != RW'(TRAIN_RUN)) begin
            run_q <= run_q + 1'b1;
            if (run_q == RW'(TRAIN_RUN - 1)) hit_q <= 1'b1;
          end
        end
        WK_CTL: begin
          in_train_q <= 1'b0;
          run_q      <= '0;
          chk_vld_q  <= 1'b1;
          chk_bad_q  <= (calc_dip != word_in[3:0]);
          acc_q      <= '0;
        end
        WK_DATA: begin
          in_train_q <= 1'b0;
          run_q      <= '0;
          acc_q      <= dip_step(acc_q, word_in);
        end
        default: ;
      endcase
    end
  end

  assign chk_vld   = chk_vld_q;
  assign chk_bad   = chk_bad_q;
  assign train_hit = hit_q;

  assert_hit_on_tdat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(vld_in && !ctl_in && word_in == TRAIN_DAT_W));
endmodule

// File: rtl/dip4_hyst.sv
module dip4_hyst #(
  parameter int GOOD_THR = 8,
  parameter int BAD_THR  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_good,
  input  logic ev_bad,
  output logic oos
);
  localparam int GW = $clog2(GOOD_THR + 1);
  localparam int BW = $clog2(BAD_THR + 1);

  logic          oos_q;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oos_q  <= 1'b1;
      good_q <= '0;
      bad_q  <= '0;
    end else if (ev_bad) begin
      good_q <= '0;
      if (!oos_q) begin
        if (bad_q == BW'(BAD_THR)) begin
          oos_q <= 1'b1;
          bad_q <= '0;
        end else begin
          bad_q <= bad_q + 1'b1;
        end
      end
    end else if (ev_good) begin
      bad_q <= '0;
      if (oos_q) begin
        if (good_q == GW'(GOOD_THR - 1)) begin
          oos_q  <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end
  end

  assign oos = oos_q;

  assert_oos_after_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oos_q) |-> $past(ev_bad) && $past(bad_q) == BW'(BAD_THR));
  assert_good_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> good_q == '0);
  assert_regain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oos_q) |-> $past(ev_good) && $past(good_q) == GW'(GOOD_THR - 1));
endmodule

// File: rtl/dip4_sync_mon.sv
module dip4_sync_mon #(
  parameter int GOOD_THR  = 8,
  parameter int BAD_THR   = 4,
  parameter int TRAIN_RUN = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] word_in,
  input  logic        ctl_in,
  input  logic        vld_in,
  input  logic        lock_in,
  output logic        err_pulse,
  output logic        dip_oos,
  output logic        train_hit,
  output logic        link_sync,
  output logic        train_req
);
  logic chk_vld, chk_bad;
  logic ev_good, ev_bad;

  dip4_accum #(.TRAIN_RUN(TRAIN_RUN)) u_accum (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .ctl_in(ctl_in),
    .vld_in(vld_in), .chk_vld(chk_vld), .chk_bad(chk_bad),
    .train_hit(train_hit)
  );

  assign ev_good = chk_vld && !chk_bad;
  assign ev_bad  = chk_vld && chk_bad;

  dip4_hyst #(.GOOD_THR(GOOD_THR), .BAD_THR(BAD_THR)) u_hyst (
    .clk(clk), .rst_n(rst_n), .ev_good(ev_good), .ev_bad(ev_bad),
    .oos(dip_oos)
  );

  assign err_pulse = ev_bad;
  assign link_sync = lock_in && !dip_oos;
  assign train_req = !link_sync;

  assert_err_on_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(vld_in && ctl_in));
  assert_err_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse || $past(vld_in && ctl_in));
endmodule

// File: tb/tb_dip4_sync_mon.sv
`timescale 1ns/1ps
module tb_dip4_sync_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_in = '0;
  logic        ctl_in = 1'b0;
  logic        vld_in = 1'b0;
  logic        lock_in = 1'b1;
  logic        err_pulse, dip_oos, train_hit, link_sync, train_req;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dip4_sync_mon #(.GOOD_THR(3), .BAD_THR(2), .TRAIN_RUN(4)) dut (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .ctl_in(ctl_in),
    .vld_in(vld_in), .lock_in(lock_in), .err_pulse(err_pulse),
    .dip_oos(dip_oos), .train_hit(train_hit), .link_sync(link_sync),
    .train_req(train_req)
  );

  // Vector table: data words, seed, corrupt, expected dip_oos after the check
  localparam int NV = 14;
  localparam int V_NDAT [NV] = '{3, 1, 5, 2, 4, 0, 3, 2, 6, 1, 2, 3, 4, 1};
  localparam int V_SEED [NV] = '{11, 23, 37, 41, 53, 67, 71, 83, 97, 101, 113, 127, 131, 149};
  localparam int V_BAD  [NV] = '{0, 0, 0, 1, 1, 0, 1, 1, 1, 0, 1, 0, 0, 0};
  localparam int V_OOS  [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0};

  logic [15:0] seg [16];
  int          seg_n;

  function automatic logic [15:0] rotl(input logic [15:0] x, input int k);
    logic [31:0] d;
    d = {x, x} << (k % 16);
    return d[31:16];
  endfunction

  // Reference parity: each word rotated by its distance from the segment end
  function automatic logic [3:0] ref_dip();
    logic [15:0] a;
    logic [3:0]  r;
    a = '0;
    for (int j = 0; j < seg_n; j++) a ^= rotl(seg[j], seg_n - 1 - j);
    r = '0;
    for (int i = 0; i < 16; i++) r[i % 4] ^= a[i];
    return r;
  endfunction

  function automatic logic [15:0] gen_word(input int s, input int j);
    return 16'(s * 937 + j * 4513) ^ 16'h5A5A;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic [15:0] w);
    @(negedge clk);
    vld_in = 1'b1; ctl_in = c; word_in = w;
  endtask

  task automatic put_data(input logic [15:0] w);
    put(1'b0, w);
    seg[seg_n] = w;
    seg_n++;
  endtask

  // Send control word, check err_pulse next cycle and dip_oos the cycle after
  task automatic put_ctl(input logic [11:0] hi, input logic corrupt,
                         input logic exp_err, input logic exp_oos, input string req);
    logic [3:0] d;
    seg[seg_n] = {hi, 4'hF};
    seg_n++;
    d = ref_dip() ^ (corrupt ? 4'h1 : 4'h0);
    put(1'b1, {hi, d});
    seg_n = 0;
    @(negedge clk);
    vld_in = 1'b0;
    check({req, " err_pulse"}, 16'(err_pulse), 16'(exp_err));
    @(negedge clk);
    check({req, " dip_oos"}, 16'(dip_oos), 16'(exp_oos));
    check({req, " err_pulse single"}, 16'(err_pulse), 16'h0);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    seg_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dip_oos", 16'(dip_oos), 16'h1);
    check("R1 link_sync", 16'(link_sync), 16'h0);
    check("R1 train_req", 16'(train_req), 16'h1);
    check("R1 err_pulse", 16'(err_pulse), 16'h0);
    check("R1 train_hit", 16'(train_hit), 16'h0);

    // R2 R5 R6 R7 table walk
    for (int v = 0; v < NV; v++) begin
      for (int j = 0; j < V_NDAT[v]; j++) put_data(gen_word(V_SEED[v], j));
      put_ctl({4'h8, 8'(V_SEED[v])}, V_BAD[v] != 0, V_BAD[v] != 0, V_OOS[v] != 0,
              "R2/R5/R6/R7 table");
    end

    // R3 empty segment: control word right after control word
    put_ctl(12'h9A5, 1'b0, 1'b0, 1'b0, "R3 empty segment");
    // R3 empty segment with corruption still detected
    put_ctl(12'h9A6, 1'b1, 1'b1, 1'b0, "R3 empty corrupt");

    // R3 invalid beats ignored
    put_data(16'h1234);
    @(negedge clk); vld_in = 1'b0; ctl_in = 1'b1; word_in = 16'hBEEF;
    @(negedge clk); vld_in = 1'b0; ctl_in = 1'b0; word_in = 16'h7777;
    put_data(16'hC0DE);
    put_ctl(12'hA11, 1'b0, 1'b0, 1'b0, "R3 vld gap");

    // R4 training words excluded and detected
    put_data(16'h0F0F);
    put_data(16'h3C3C);
    put(1'b1, 16'h0FFF);
    put(1'b0, 16'hF000);
    put(1'b0, 16'hF000);
    put(1'b0, 16'hF000);
    @(negedge clk);
    check("R4 no early hit", 16'(train_hit), 16'h0);
    vld_in = 1'b1; ctl_in = 1'b0; word_in = 16'hF000;
    @(negedge clk);
    vld_in = 1'b0;
    check("R4 train_hit", 16'(train_hit), 16'h1);
    @(negedge clk);
    check("R4 train_hit one cycle", 16'(train_hit), 16'h0);
    put_ctl(12'hB22, 1'b0, 1'b0, 1'b0, "R4 training excluded");

    // R8 lock gating
    @(negedge clk);
    check("R8 link_sync locked", 16'(link_sync), 16'h1);
    check("R8 train_req locked", 16'(train_req), 16'h0);
    lock_in = 1'b0;
    @(negedge clk);
    check("R8 link_sync unlocked", 16'(link_sync), 16'h0);
    check("R8 train_req unlocked", 16'(train_req), 16'h1);
    lock_in = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule